// File: doc/BRIEF.md
# RC Ramp Analog-to-Digital Timing Controller

This block turns the time an external RC network takes to cross an unknown voltage into a digital code. A request on `start_i` makes the block hold `ramp_ctl_o` high for a fixed number of clocks, which pre-charges the capacitor node to the top of the input range. It then drops `ramp_ctl_o`, so the node begins an exponential decay, and starts a tick counter in that same cycle. An external comparator reports when the decaying node has crossed the unknown voltage. The block brings that level into its clock domain through a chain of flops and stops the counter.

The code on `result_o` is the bitwise complement of the stopped count, and `done_o` pulses for one clock when it is updated. A slow crossing therefore gives a small code, and a fast crossing gives a large one. The code follows the exponential curve of the RC node and is not linear in the input voltage. If no crossing is seen by the time the counter would pass its top value, the conversion ends anyway, the code is zero and `ovf_o` is set. A tick prescaler divides the system clock down. With its default setting it gives one count per microsecond at 125 MHz, so an 8-bit conversion lasts at most 256 µs after the discharge phase.

Top module: `rc_ramp_adc`

## Requirements
- R1: A `start_i` seen high at a clock edge while the block is idle makes `ramp_ctl_o` high for exactly DISCH_CYCLES consecutive clocks, beginning with the cycle after that edge.
- R2: In the first cycle that `ramp_ctl_o` is low after the discharge phase, the count is 0. It then rises by one every CLK_PER_TICK clocks.
- R3: While the ramp runs, the first clock edge at which the synchronised comparator level shows a trip ends the conversion. The new `result_o` is the bitwise complement of the count held at that edge, so a trip before the first tick gives all ones.
- R4: The comparator input passes through SYNC_STAGES flops, two by default. A level on `cmp_i` set up before edge e is acted on at edge e+2, and `done_o` is high in the cycle after that edge.
- R5: While the block is idle or in the discharge phase, the comparator level has no effect: no `done_o`, and `result_o` does not change.
- R6: If the count is at its top value (255 for 8 bits) when a further tick falls due with no trip, the conversion ends with `result_o` = 0 and `ovf_o` = 1. A conversion ended by a trip clears `ovf_o`, even when the complemented count happens to be zero.
- R7: `done_o` is high for exactly one clock per conversion. `result_o` and `ovf_o` keep their value until the next conversion ends.
- R8: A `start_i` seen while a conversion is in its discharge or ramp phase is ignored: the discharge length and the result of that conversion are unchanged, and no further conversion follows it.
- R9: During and directly after reset, `ramp_ctl_o`, `done_o`, `ovf_o` and `result_o` are all 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled only when idle |
| cmp_i | input | 1 | Asynchronous comparator output; active level set by TRIP_HIGH |
| ramp_ctl_o | output | 1 | High to pre-charge the RC node; low releases the ramp |
| result_o | output | RES_W | Complement of the stopped count |
| done_o | output | 1 | One-clock pulse when result_o is updated |
| ovf_o | output | 1 | Set when the last conversion ran out of counts |

## Verification
The bench aims at the code boundaries. A comparator already tripped when the ramp starts must give all ones; a late trip must give zero with the overflow flag clear; a missing trip must give zero with the flag set, after exactly 256 ticks. A design that counted the first tick early, or that lost a synchroniser stage, would give codes one step off at these points. It would also get the latency from `cmp_i` to `done_o` wrong. Comparator activity during idle and discharge, and start requests during a conversion, are applied to catch a design that leaks a trip before the ramp starts, or that restarts or stretches the discharge.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DISCH = 2'd1,
      ST_RAMP  = 2'd2
   } rcadc_state_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rcadc_sync.sv
module rcadc_sync #(
   parameter int unsigned STAGES      = 2,
   parameter bit          ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic              level;
   logic [STAGES-1:0] chain;

   generate
      if (ACTIVE_HIGH) begin : g_pol_hi
         assign level = async_i;
      end else begin : g_pol_lo
         assign level = ~async_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], level};
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/rcadc_tick.sv
module rcadc_tick #(
   parameter int unsigned DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_div1
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick_o     = run_i;
      end else begin : g_divn
         localparam int unsigned PW = rcadc_pkg::bits_for(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pre <= '0;
            else if (!run_i)     pre <= '0;
            else if (pre == LAST) pre <= '0;
            else                 pre <= pre + PW'(1);
         end

         assign tick_o = run_i && (pre == LAST);
      end
   endgenerate
endmodule

// File: rtl/rcadc_seq.sv
module rcadc_seq
   import rcadc_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned DISCH_CYCLES = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             trip_i,
   input  logic             tick_i,
   output logic             run_o,
   output logic             ramp_ctl_o,
   output logic [CNT_W-1:0] result_o,
   output logic             ovf_o,
   output logic             done_o
);
   localparam int unsigned    DW       = rcadc_pkg::bits_for(DISCH_CYCLES);
   localparam logic [DW-1:0]  D_LAST   = DW'(DISCH_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   rcadc_state_e     state;
   logic [DW-1:0]    dcnt;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dcnt     <= '0;
         cnt      <= '0;
         result_o <= '0;
         ovf_o    <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state <= ST_DISCH;
                  dcnt  <= '0;
               end
            end
            ST_DISCH: begin
               if (dcnt == D_LAST) begin
                  state <= ST_RAMP;
                  cnt   <= '0;
               end else begin
                  dcnt <= dcnt + DW'(1);
               end
            end
            ST_RAMP: begin
               if (trip_i) begin
                  result_o <= ~cnt;
                  ovf_o    <= 1'b0;
                  done_o   <= 1'b1;
                  state    <= ST_IDLE;
               end else if (tick_i) begin
                  if (cnt == CNT_TOP) begin
                     result_o <= '0;
                     ovf_o    <= 1'b1;
                     done_o   <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ramp_ctl_o = (state == ST_DISCH);
   assign run_o      = (state == ST_RAMP);
endmodule

// File: rtl/rc_ramp_adc.sv
module rc_ramp_adc #(
   parameter int unsigned CLK_PER_TICK = 125,
   parameter int unsigned DISCH_CYCLES = 2000,
   parameter int unsigned RES_W        = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          TRIP_HIGH    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic             ramp_ctl_o,
   output logic [RES_W-1:0] result_o,
   output logic             done_o,
   output logic             ovf_o
);
   generate
      if (RES_W < 2 || RES_W > 24) begin : g_bad_res
         $error("RES_W out of range 2..24");
      end
      if (CLK_PER_TICK < 1) begin : g_bad_div
         $error("CLK_PER_TICK must be at least 1");
      end
      if (DISCH_CYCLES < 1) begin : g_bad_disch
         $error("DISCH_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic trip;
   logic tick;
   logic run;

   rcadc_sync #(
      .STAGES      (SYNC_STAGES),
      .ACTIVE_HIGH (TRIP_HIGH)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (cmp_i),
      .sync_o  (trip)
   );

   rcadc_tick #(
      .DIV (CLK_PER_TICK)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   rcadc_seq #(
      .CNT_W        (RES_W),
      .DISCH_CYCLES (DISCH_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .trip_i     (trip),
      .tick_i     (tick),
      .run_o      (run),
      .ramp_ctl_o (ramp_ctl_o),
      .result_o   (result_o),
      .ovf_o      (ovf_o),
      .done_o     (done_o)
   );
endmodule

// File: rtl/rc_ramp_adc_chk.sv
module rc_ramp_adc_chk #(
   parameter int unsigned DISCH_CYCLES = 2000,
   parameter int unsigned RES_W        = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ramp_ctl_o,
   input logic             done_o,
   input logic             ovf_o,
   input logic [RES_W-1:0] result_o
);
   int unsigned hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_run <= 0;
      else if (ramp_ctl_o) hi_run <= hi_run + 1;
      else                 hi_run <= 0;
   end

   assert_disch_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ramp_ctl_o) |-> (hi_run == DISCH_CYCLES));

   assert_no_done_in_disch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_ctl_o |-> !done_o);

   assert_ovf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o) |-> (result_o == '0));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(ovf_o)));

   assert_no_start_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !ramp_ctl_o);
endmodule

bind rc_ramp_adc rc_ramp_adc_chk #(
   .DISCH_CYCLES (DISCH_CYCLES),
   .RES_W        (RES_W)
) u_chk (.*);

// File: tb/sim_rc_ramp_adc.sv
module sim_rc_ramp_adc;
   localparam int P = 4;
   localparam int D = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, start_i = 1'b0, cmp_i = 1'b0;
   logic ramp_ctl_o, done_o, ovf_o;
   logic [W-1:0] result_o;

   rc_ramp_adc #(.CLK_PER_TICK(P), .DISCH_CYCLES(D), .RES_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .ramp_ctl_o(ramp_ctl_o), .result_o(result_o), .done_o(done_o), .ovf_o(ovf_o));

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   int m_st = 0, m_d = 0, m_pre = 0, m_cnt = 0, m_s1 = 0, m_s2 = 0;
   int m_res = 0, m_ovf = 0, m_done = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_d = 0; m_pre = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
         m_res = 0; m_ovf = 0; m_done = 0;
      end else begin
         m_done = 0;
         case (m_st)
            0: if (start_i) begin m_st = 1; m_d = 0; end
            1: begin
               m_d++;
               if (m_d == D) begin m_st = 2; m_cnt = 0; m_pre = 0; end
            end
            default: begin
               if (m_s2 != 0) begin
                  m_res = (~m_cnt) & 255; m_ovf = 0; m_done = 1; m_st = 0;
               end else begin
                  m_pre++;
                  if (m_pre == P) begin
                     m_pre = 0;
                     if (m_cnt == 255) begin
                        m_res = 0; m_ovf = 1; m_done = 1; m_st = 0;
                     end else m_cnt++;
                  end
               end
            end
         endcase
         m_s2 = m_s1;
         m_s1 = int'(cmp_i);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(ramp_ctl_o == (m_st == 1), "R1 model ramp_ctl", ramp_ctl_o, m_st == 1);
         chk(done_o == m_done[0], "R7 model done", done_o, m_done);
         chk(result_o == m_res[7:0], "R3 model result", result_o, m_res);
         chk(ovf_o == m_ovf[0], "R6 model ovf", ovf_o, m_ovf);
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
      end
   end

   task automatic kick();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   // returns at negedge of first ramp cycle; hi = discharge length seen
   task automatic wait_ramp(output int hi);
      hi = 0;
      while (!ramp_ctl_o) @(negedge clk);
      while (ramp_ctl_o) begin hi++; @(negedge clk); end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!done_o) begin n++; @(negedge clk); end
   endtask

   task automatic convert_at(input int w);
      int hi, n, code;
      kick();
      wait_ramp(hi);
      chk(hi == D, "R1 discharge length", hi, D);
      repeat (w) @(negedge clk);
      cmp_i = 1'b1;
      wait_done(n);
      code = (~((w + 2) / P)) & 255;
      chk(n == 3, "R4 trip latency", n, 3);
      chk(result_o == code[7:0], "R3 trip code", result_o, code);
      chk(ovf_o == 1'b0, "R6 trip clears ovf", ovf_o, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
      cmp_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int hi, n;
      logic [W-1:0] keep;
      repeat (3) @(negedge clk);
      chk({ramp_ctl_o, done_o, ovf_o, result_o} == '0, "R9 in reset",
          {ramp_ctl_o, done_o, ovf_o, result_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ramp_ctl_o, done_o, ovf_o, result_o} == '0, "R9 after reset",
          {ramp_ctl_o, done_o, ovf_o, result_o}, 0);

      // R5: comparator in idle does nothing
      cmp_i = 1'b1;
      n = 0;
      repeat (20) begin @(negedge clk); if (done_o || ramp_ctl_o) n++; end
      chk(n == 0, "R5 idle comparator ignored", n, 0);
      chk(result_o == '0, "R5 idle result unchanged", result_o, 0);

      // R3: already tripped at ramp start -> all ones
      kick();
      wait_ramp(hi);
      wait_done(n);
      chk(n == 1, "R3 early trip latency", n, 1);
      chk(result_o == 8'hFF, "R3 early trip code", result_o, 8'hFF);
      cmp_i = 1'b0;
      repeat (3) @(negedge clk);

      // R2 with distinct trip points
      convert_at(0);
      convert_at(37);
      convert_at(400);
      convert_at(1017);
      convert_at(1018);

      // R5: comparator high in discharge, released before ramp
      cmp_i = 1'b1;
      kick();
      while (!ramp_ctl_o) @(negedge clk);
      repeat (3) @(negedge clk);
      cmp_i = 1'b0;
      wait_ramp(hi);
      repeat (20) @(negedge clk);
      cmp_i = 1'b1;
      wait_done(n);
      chk(result_o == 8'hFA, "R5 discharge trip ignored", result_o, 8'hFA);
      cmp_i = 1'b0;
      repeat (3) @(negedge clk);

      // R6 overflow, with R8 start pulses during discharge and ramp
      kick();
      while (!ramp_ctl_o) @(negedge clk);
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      wait_ramp(hi);
      chk(hi == D - 3, "R8 discharge not restarted", hi, D - 3);
      repeat (50) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      n = 51;
      while (!done_o) begin n++; @(negedge clk); end
      chk(n == 256 * P, "R6 overflow timing", n, 256 * P);
      chk(result_o == '0, "R6 overflow code", result_o, 0);
      chk(ovf_o == 1'b1, "R6 overflow flag", ovf_o, 1);
      keep = result_o;
      n = 0;
      repeat (20) begin @(negedge clk); if (ramp_ctl_o || done_o) n++; end
      chk(n == 0, "R8 no extra conversion", n, 0);
      chk(result_o == keep && ovf_o, "R7 result held", {ovf_o, result_o}, {1'b1, keep});

      summary();
   end
endmodule